// File: doc/BRIEF.md
# Video Sync Timing Controller

This block keeps the horizontal position, the line number, the field parity and the position in the colour field sequence of a video raster, all counted on the pixel clock. In master operation it runs purely on its own counters. In slave operation the counters still run freely, but an edge on an external reference input pulls them back into phase. The selected reference type decides which counters that edge reloads, and the selected colour standard sets the length of the field sequence.

The block also produces a horizontal pulse. It is high for the part of each line that falls between a programmable start position and a programmable stop position. It can be held low on the vertical blanking lines, so the same output can serve as a composite blanking signal. Line length, lines per field and the number of blanking lines are parameters.

Top module: `vid_sync_timer`

## Requirements
- R1: After reset, hCount = 0, vCount = 0, oddField = 1, fieldSeq = 0, palPhase = 0 and scPhaseReset = 0.
- R2: Without an active reference edge:
  - hCount counts 0 to H_TOTAL-1 and wraps.
  - vCount goes up by one at each line end and wraps after V_TOTAL-1.
  - oddField toggles at each field end.
  - palPhase toggles at each line end.
- R3: fieldSeq goes up by one at each field end and wraps to 0 after the last field of the sequence. The sequence is 4 fields for stdSel 0 (NTSC), 8 for stdSel 1 (PAL), 12 for stdSel 2 (SECAM) and 4 for stdSel 3.
- R4: With slaveMode = 0, refIn has no effect on any counter output.
- R5: The active edge of refIn is the rising edge when refPolarity = 0 and the falling edge when refPolarity = 1. The other edge does nothing. An active edge that arrives between clock edges is applied at the third rising clock edge that follows it.
- R6: With refType 0 (vertical sync), an active edge sets vCount to 0. hCount, oddField and fieldSeq keep running undisturbed.
- R7: With refType 1 (odd/even), an active edge sets vCount to 0 and oddField to 1. It sets hCount to 0 only when hLockEn = 1.
- R8: With refType 2 or 3 (field sequence), an active edge does what R7 describes and also sets fieldSeq to 0 and palPhase to 0. When scResetEn = 1, scPhaseReset is high for exactly one cycle, in the same cycle that the counters are reloaded.
- R9: Every active edge re-phases the counters, whatever its timing. Surplus edges are not filtered out.
- R10: hPulseOut is high exactly when hStart <= hCount < hStop, in the same cycle as the count.
- R11: When blankInhibit = 1 and vCount < VBLANK_LINES, hPulseOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveMode | input | 1 | 1 = follow refIn, 0 = master (refIn ignored) |
| refIn | input | 1 | Asynchronous reference pulse |
| refPolarity | input | 1 | 0 = rising edge active, 1 = falling edge active |
| refType | input | 2 | 0 vertical sync, 1 odd/even, 2 or 3 field sequence |
| stdSel | input | 2 | 0 NTSC, 1 PAL, 2 SECAM, 3 treated as 4-field |
| hLockEn | input | 1 | Allow odd/even and field-sequence edges to reload hCount |
| scResetEn | input | 1 | Allow a field-sequence edge to emit scPhaseReset |
| hStart | input | H_W | First position of the horizontal pulse |
| hStop | input | H_W | First position after the horizontal pulse |
| blankInhibit | input | 1 | Hold the pulse low on vertical blanking lines |
| hPulseOut | output | 1 | Programmable horizontal pulse |
| hCount | output | H_W | Horizontal position |
| vCount | output | V_W | Line within field |
| oddField | output | 1 | Field parity flag, 1 = odd field |
| fieldSeq | output | 4 | Field index in the colour sequence |
| palPhase | output | 1 | Line alternation phase |
| scPhaseReset | output | 1 | One-cycle subcarrier phase reset strobe |

## Verification
Long free-running sweeps compare every output on every cycle with values worked out from the cycle count. These sweeps would expose a counter that is off by one at a wrap, or a field sequence whose length does not follow the standard. The master sweep toggles refIn the whole time, so a master mode that leaks the reference shows up as a jump in the counts. Directed edges are placed at known counts and checked at the third clock edge afterwards. They catch a wrong edge polarity, a vertical-sync edge that also resets hCount, an odd/even edge that ignores hLockEn, and a field-sequence edge that leaves fieldSeq or palPhase alone or drops the subcarrier strobe. A second edge inside the same field catches logic that filters surplus edges.

// File: rtl/vst_pkg.sv
package vst_pkg;

  typedef enum logic [1:0] {
    REF_VSYNC   = 2'd0,
    REF_ODDEVEN = 2'd1,
    REF_FSEQ    = 2'd2,
    REF_FSEQ_B  = 2'd3
  } refKind_e;

  typedef enum logic [1:0] {
    STD_NTSC  = 2'd0,
    STD_PAL   = 2'd1,
    STD_SECAM = 2'd2,
    STD_OTHER = 2'd3
  } vidStd_e;

  typedef struct packed {
    logic loadV;
    logic loadH;
    logic setOdd;
    logic resetSeq;
    logic resetPal;
    logic resetSc;
  } phaseStrb_t;

  function automatic logic [3:0] seqLenFor(input vidStd_e std);
    case (std)
      STD_PAL:   return 4'd8;
      STD_SECAM: return 4'd12;
      default:   return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/vst_ctrl.sv
module vst_ctrl
  import vst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slaveMode,
  input  logic       refIn,
  input  logic       refPolarity,
  input  logic [1:0] refType,
  input  logic       hLockEn,
  input  logic       scResetEn,
  output phaseStrb_t strb
);

  logic syncA, syncB, prevB;
  logic riseSeen, fallSeen, activeEdge;
  refKind_e kind;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= refIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign riseSeen   = syncB & ~prevB;
  assign fallSeen   = ~syncB & prevB;
  assign activeEdge = slaveMode & (refPolarity ? fallSeen : riseSeen);
  assign kind       = refKind_e'(refType);

  always_comb begin
    strb = '0;
    if (activeEdge) begin
      strb.loadV = 1'b1;
      if (kind != REF_VSYNC) begin
        strb.setOdd = 1'b1;
        strb.loadH  = hLockEn;
      end
      if (kind == REF_FSEQ || kind == REF_FSEQ_B) begin
        strb.resetSeq = 1'b1;
        strb.resetPal = 1'b1;
        strb.resetSc  = scResetEn;
      end
    end
  end

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadV |=> !strb.loadV); // R5

  AST_HLOCK_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadH |-> strb.setOdd); // R7

endmodule

// File: rtl/vst_datapath.sv
module vst_datapath
  import vst_pkg::*;
#(
  parameter int H_TOTAL      = 858,
  parameter int V_TOTAL      = 263,
  parameter int VBLANK_LINES = 20,
  localparam int H_W = $clog2(H_TOTAL),
  localparam int V_W = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rstN,
  input  phaseStrb_t     strb,
  input  logic [1:0]     stdSel,
  input  logic [H_W-1:0] hStart,
  input  logic [H_W-1:0] hStop,
  input  logic           blankInhibit,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] vCount,
  output logic           oddField,
  output logic [3:0]     fieldSeq,
  output logic           palPhase,
  output logic           scPhaseReset,
  output logic           hPulseOut
);

  localparam logic [H_W-1:0] H_LAST   = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0] V_LAST   = V_W'(V_TOTAL - 1);
  localparam logic [V_W-1:0] V_BLANKS = V_W'(VBLANK_LINES);

  logic       hWrap, vWrap, fieldEnd, inWindow, inBlank;
  logic [3:0] seqLen;

  assign hWrap    = (hCount == H_LAST);
  assign vWrap    = (vCount == V_LAST);
  assign fieldEnd = hWrap & vWrap & ~strb.loadV;
  assign seqLen   = seqLenFor(vidStd_e'(stdSel));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount       <= '0;
      vCount       <= '0;
      oddField     <= 1'b1;
      fieldSeq     <= '0;
      palPhase     <= 1'b0;
      scPhaseReset <= 1'b0;
    end else begin
      if (strb.loadH || hWrap) hCount <= '0;
      else                     hCount <= hCount + 1'b1;

      if (strb.loadV)  vCount <= '0;
      else if (hWrap)  vCount <= vWrap ? '0 : vCount + 1'b1;

      if (strb.setOdd)   oddField <= 1'b1;
      else if (fieldEnd) oddField <= ~oddField;

      if (strb.resetSeq) fieldSeq <= '0;
      else if (fieldEnd) fieldSeq <= (fieldSeq >= seqLen - 4'd1) ? 4'd0 : fieldSeq + 4'd1;

      if (strb.resetPal) palPhase <= 1'b0;
      else if (hWrap)    palPhase <= ~palPhase;

      scPhaseReset <= strb.resetSc;
    end
  end

  assign inWindow  = (hCount >= hStart) && (hCount < hStop);
  assign inBlank   = (vCount < V_BLANKS);
  assign hPulseOut = inWindow && !(blankInhibit && inBlank);

  AST_H_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    hCount <= H_LAST); // R2

  AST_V_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (hWrap && !vWrap && !strb.loadV) |=> (vCount == $past(vCount) + 1'b1)); // R2

  AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fieldSeq < 4'd12); // R3

  AST_LOAD_V: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadV |=> (vCount == '0)); // R6

  AST_SC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    scPhaseReset |=> !scPhaseReset); // R8

  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (blankInhibit && vCount < V_BLANKS) |-> !hPulseOut); // R11

endmodule

// File: rtl/vid_sync_timer.sv
module vid_sync_timer
  import vst_pkg::*;
#(
  parameter int H_TOTAL      = 858,
  parameter int V_TOTAL      = 263,
  parameter int VBLANK_LINES = 20,
  localparam int H_W = $clog2(H_TOTAL),
  localparam int V_W = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           slaveMode,
  input  logic           refIn,
  input  logic           refPolarity,
  input  logic [1:0]     refType,
  input  logic [1:0]     stdSel,
  input  logic           hLockEn,
  input  logic           scResetEn,
  input  logic [H_W-1:0] hStart,
  input  logic [H_W-1:0] hStop,
  input  logic           blankInhibit,
  output logic           hPulseOut,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] vCount,
  output logic           oddField,
  output logic [3:0]     fieldSeq,
  output logic           palPhase,
  output logic           scPhaseReset
);

  phaseStrb_t strb;

  vst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .slaveMode  (slaveMode),
    .refIn      (refIn),
    .refPolarity(refPolarity),
    .refType    (refType),
    .hLockEn    (hLockEn),
    .scResetEn  (scResetEn),
    .strb       (strb)
  );

  vst_datapath #(
    .H_TOTAL     (H_TOTAL),
    .V_TOTAL     (V_TOTAL),
    .VBLANK_LINES(VBLANK_LINES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stdSel      (stdSel),
    .hStart      (hStart),
    .hStop       (hStop),
    .blankInhibit(blankInhibit),
    .hCount      (hCount),
    .vCount      (vCount),
    .oddField    (oddField),
    .fieldSeq    (fieldSeq),
    .palPhase    (palPhase),
    .scPhaseReset(scPhaseReset),
    .hPulseOut   (hPulseOut)
  );

  AST_MASTER_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && $past(!slaveMode) && $past(rstN)) |->
      (hCount == (($past(hCount) == H_W'(H_TOTAL - 1)) ? '0 : $past(hCount) + 1'b1))); // R4

endmodule

// File: tb/vid_sync_timer_tb.sv
module vid_sync_timer_tb;

  localparam int H = 16;
  localparam int V = 6;
  localparam int VB = 2;
  localparam int HW = $clog2(H);
  localparam int VW = $clog2(V);
  localparam int FIELD = H * V;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveMode = 1'b1, refIn = 1'b0, refPolarity = 1'b0;
  logic [1:0] refType = 2'd0, stdSel = 2'd0;
  logic hLockEn = 1'b0, scResetEn = 1'b0, blankInhibit = 1'b0;
  logic [HW-1:0] hStart = 4'd3, hStop = 4'd9;
  logic hPulseOut, oddField, palPhase, scPhaseReset;
  logic [HW-1:0] hCount;
  logic [VW-1:0] vCount;
  logic [3:0] fieldSeq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vid_sync_timer #(.H_TOTAL(H), .V_TOTAL(V), .VBLANK_LINES(VB)) u_dut (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .refIn(refIn),
    .refPolarity(refPolarity), .refType(refType), .stdSel(stdSel),
    .hLockEn(hLockEn), .scResetEn(scResetEn), .hStart(hStart), .hStop(hStop),
    .blankInhibit(blankInhibit), .hPulseOut(hPulseOut), .hCount(hCount),
    .vCount(vCount), .oddField(oddField), .fieldSeq(fieldSeq),
    .palPhase(palPhase), .scPhaseReset(scPhaseReset)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
  endtask

  function automatic int seqLenOf(input logic [1:0] s);
    return (s == 2'd1) ? 8 : (s == 2'd2) ? 12 : 4;
  endfunction

  // Free-run sweep; every output compared with values derived from the cycle count.
  task automatic sweep(input string tag, input int n, input bit toggleRef);
    for (int i = 1; i <= n; i++) begin
      if (toggleRef) refIn = ((i / 7) % 2) == 1;
      tick(1);
      begin
        int line, field, h, v;
        bit expPulse;
        h = i % H;
        line = i / H;
        v = line % V;
        field = line / V;
        expPulse = (h >= hStart) && (h < hStop) && !(blankInhibit && v < VB);
        chk(tag, "hCount", hCount, h);
        chk(tag, "vCount", vCount, v);
        chk(tag, "oddField", oddField, (field % 2) == 0);
        chk(tag, "palPhase", palPhase, line % 2);
        chk("R3", "fieldSeq", fieldSeq, field % seqLenOf(stdSel));
        chk(blankInhibit ? "R11" : "R10", "hPulseOut", hPulseOut, expPulse);
      end
    end
  endtask

  initial begin
    // Sweep A: slave with no reference pulses, NTSC, blanking inhibit on
    slaveMode = 1'b1; stdSel = 2'd0; blankInhibit = 1'b1; hStart = 4'd3; hStop = 4'd9;
    doReset();
    chk("R1", "hCount", hCount, 0);
    chk("R1", "vCount", vCount, 0);
    chk("R1", "oddField", oddField, 1);
    chk("R1", "fieldSeq", fieldSeq, 0);
    chk("R1", "palPhase", palPhase, 0);
    chk("R1", "scPhaseReset", scPhaseReset, 0);
    sweep("R2", 9 * FIELD, 1'b0);

    // Sweep B: master mode, reference toggling, field-sequence type, SECAM
    slaveMode = 1'b0; refType = 2'd2; hLockEn = 1'b1; scResetEn = 1'b1;
    stdSel = 2'd2; blankInhibit = 1'b0; hStart = 4'd0; hStop = 4'd5;
    doReset();
    sweep("R4", 13 * FIELD, 1'b1);
    chk("R4", "scPhaseReset", scPhaseReset, 0);

    // Sweep C: PAL, slave, no pulses, other window
    slaveMode = 1'b1; refIn = 1'b0; stdSel = 2'd1; blankInhibit = 1'b1;
    hStart = 4'd5; hStop = 4'd15;
    doReset();
    sweep("R2", 9 * FIELD, 1'b0);

    // Vertical-sync type: only vCount reloads, then a surplus edge
    refType = 2'd0; hLockEn = 1'b1; scResetEn = 1'b0; stdSel = 2'd0; refIn = 1'b0;
    doReset();
    tick(20);
    refIn = 1'b1;
    tick(3);
    chk("R6", "hCount", hCount, 7);
    chk("R6", "vCount", vCount, 0);
    chk("R6", "oddField", oddField, 1);
    chk("R5", "vCount latency", vCount, 0);
    tick(9);
    chk("R6", "vCount next line", vCount, 1);
    chk("R6", "hCount wrap", hCount, 0);
    refIn = 1'b0;
    tick(5);
    refIn = 1'b1;
    tick(3);
    chk("R9", "vCount surplus edge", vCount, 0);
    chk("R9", "hCount", hCount, 8);

    // Odd/even without horizontal lock
    refType = 2'd1; hLockEn = 1'b0; refIn = 1'b0;
    doReset();
    tick(133);
    chk("R2", "oddField before", oddField, 0);
    refIn = 1'b1;
    tick(2);
    chk("R5", "vCount before apply", vCount, 2);
    tick(1);
    chk("R7", "hCount kept", hCount, 8);
    chk("R7", "vCount", vCount, 0);
    chk("R7", "oddField", oddField, 1);

    // Odd/even with horizontal lock
    hLockEn = 1'b1; refIn = 1'b0;
    doReset();
    tick(133);
    refIn = 1'b1;
    tick(3);
    chk("R7", "hCount locked", hCount, 0);
    chk("R7", "vCount", vCount, 0);
    chk("R7", "oddField", oddField, 1);
    tick(1);
    chk("R7", "hCount after", hCount, 1);

    // Falling-edge polarity: rising edge ignored, falling edge applies
    refPolarity = 1'b1; refIn = 1'b1;
    doReset();
    tick(40);
    chk("R5", "hCount rising ignored", hCount, 8);
    chk("R5", "vCount rising ignored", vCount, 2);
    refIn = 1'b0;
    tick(3);
    chk("R5", "hCount falling", hCount, 0);
    chk("R5", "vCount falling", vCount, 0);
    refPolarity = 1'b0;

    // Field-sequence type, PAL, subcarrier reset enabled
    refType = 2'd2; stdSel = 2'd1; hLockEn = 1'b1; scResetEn = 1'b1; refIn = 1'b0;
    doReset();
    tick(3 * FIELD + 20);
    chk("R3", "fieldSeq before", fieldSeq, 3);
    chk("R2", "palPhase before", palPhase, 1);
    refIn = 1'b1;
    tick(3);
    chk("R8", "hCount", hCount, 0);
    chk("R8", "vCount", vCount, 0);
    chk("R8", "oddField", oddField, 1);
    chk("R8", "fieldSeq", fieldSeq, 0);
    chk("R8", "palPhase", palPhase, 0);
    chk("R8", "scPhaseReset high", scPhaseReset, 1);
    tick(1);
    chk("R8", "scPhaseReset one cycle", scPhaseReset, 0);
    tick(7 * FIELD - 1);
    chk("R3", "fieldSeq PAL 7", fieldSeq, 7);
    tick(FIELD);
    chk("R3", "fieldSeq PAL wrap", fieldSeq, 0);

    // Field-sequence type with subcarrier reset disabled
    scResetEn = 1'b0; refIn = 1'b0;
    doReset();
    tick(3 * FIELD + 20);
    refIn = 1'b1;
    tick(3);
    chk("R8", "fieldSeq no sc", fieldSeq, 0);
    chk("R8", "scPhaseReset off", scPhaseReset, 0);
    tick(1);
    chk("R8", "scPhaseReset still off", scPhaseReset, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 60000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule